// File: doc/BRIEF.md
# Byte range and match compare unit

This unit tests a single byte against a packed description held in a second operand and reports the outcome as a 4-bit condition field. The byte under test is always the least significant byte of the first operand. In range mode the second operand carries one or two inclusive, unsigned byte intervals. In match mode every byte lane of the second operand is a candidate value. The unit is a good fit for character-class tests such as "is this an upper-case letter" or "is this a delimiter".

The comparison logic is combinational. The result is captured in a register one cycle after `in_valid` is sampled high. Only the greater-than position of the condition field can ever be set. Writing the field into a condition register file is left to the surrounding pipeline.

Top module: `byte_cmp_unit`

## Requirements
- R1: A synchronous reset drives `out_valid` to 0 and `cond_out` to 4'b0000.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was sampled high. `cond_out` carries that request's result in the same cycle.
- R3: The probe byte is `opnd_a[7:0]`. Bits 63:8 of `opnd_a` have no effect on the result in either mode.
- R4: In range mode (`op_sel` = 0) the first interval has its lower bound at `opnd_b[7:0]` and its upper bound at `opnd_b[15:8]`. It matches when lower <= probe <= upper, using unsigned compares. Both bounds are inclusive.
- R5: When `dual_range` = 1 in range mode, a second interval is also tested, with its lower bound at `opnd_b[23:16]` and its upper bound at `opnd_b[31:24]`. The result is true when either interval matches.
- R6: When `dual_range` = 0 in range mode, only the first interval is tested, and `opnd_b[31:16]` has no effect.
- R7: In range mode, `opnd_b[63:32]` has no effect on the result.
- R8: An interval whose lower bound exceeds its upper bound matches no byte and raises no error.
- R9: In match mode (`op_sel` = 1, available when OPND_W is 64) the result is true when any of the eight byte lanes of `opnd_b` equals the probe byte. `dual_range` has no effect in this mode.
- R10: The condition field is ordered {LT, GT, EQ, SO} from bit 3 down to bit 0. A true result gives 4'b0100 and a false result gives 4'b0000.
- R11: While `in_valid` is low, `cond_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe; operands are sampled when high |
| op_sel | input | 1 | 0 = range compare, 1 = equal-any-byte match |
| dual_range | input | 1 | Range mode only: 1 also tests the second interval |
| opnd_a | input | 64 | Operand holding the probe byte in bits 7:0 |
| opnd_b | input | 64 | Packed interval bounds or match lanes |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| cond_out | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The bench targets a probe that sits exactly on a lower or upper bound. A design using strict compares would miss these cases. It also targets inverted intervals, which a design that swapped or sorted the bounds would report as hits. The bench fills the high bits of the first operand and of the second operand's upper word with lookalike values, and sets the second interval while only one interval is enabled. A decoder that reached past the allowed fields would turn these into false hits. Match probes sit in the lowest and highest lanes, so that an off-by-one lane loop is exposed. Idle cycles after a result show whether a design lets the output drift when no request is present.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned RANGE_MAX = 2;
    localparam int unsigned BOUND_W   = 2 * BYTE_W;
    localparam int unsigned COND_W    = 4;
    localparam int unsigned GT_POS    = 2;

    typedef enum logic {
        OP_RANGE = 1'b0,
        OP_MATCH = 1'b1
    } cmp_op_e;

    typedef struct packed {
        logic              vld;
        logic [COND_W-1:0] cond;
    } cmp_state_t;

    function automatic logic [COND_W-1:0] gt_field(input logic flag);
        logic [COND_W-1:0] f;
        f         = '0;
        f[GT_POS] = flag;
        return f;
    endfunction

endpackage

// File: rtl/bcu_range_slot.sv
module bcu_range_slot
    import bcu_pkg::*;
(
    input  logic              en,
    input  logic [BYTE_W-1:0] probe,
    input  logic [BYTE_W-1:0] lo_bound,
    input  logic [BYTE_W-1:0] hi_bound,
    output logic              hit
);

    logic above_lo;
    logic below_hi;

    always_comb begin
        above_lo = (probe >= lo_bound);
        below_hi = (probe <= hi_bound);
        hit      = en & above_lo & below_hi;
    end

    // An inverted interval can never report a hit (R8)
    always_comb begin
        if (lo_bound > hi_bound) begin
            p_empty_interval_r8: assert (hit !== 1'b1);
        end
    end

endmodule

// File: rtl/bcu_lane_match.sv
module bcu_lane_match
    import bcu_pkg::*;
#(
    parameter int unsigned LANES = 8
) (
    input  logic [BYTE_W-1:0]       probe,
    input  logic [LANES*BYTE_W-1:0] word,
    output logic                    any_hit
);

    logic [LANES-1:0] lane_eq;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_eq[g] = (word[g*BYTE_W +: BYTE_W] == probe);
    end

    assign any_hit = |lane_eq;

endmodule

// File: rtl/byte_cmp_unit.sv
module byte_cmp_unit
    import bcu_pkg::*;
#(
    parameter int unsigned OPND_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              op_sel,
    input  logic              dual_range,
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    output logic              out_valid,
    output logic [3:0]        cond_out
);

    localparam int unsigned LANES    = OPND_W / BYTE_W;
    localparam bit          MATCH_OK = (OPND_W >= 64);

    cmp_op_e           op_e;
    logic [BYTE_W-1:0] probe;
    logic [RANGE_MAX-1:0] slot_hit;
    logic              range_hit;
    logic              match_hit;
    cmp_state_t        st_d;
    cmp_state_t        st_q;

    assign op_e  = cmp_op_e'(op_sel);
    assign probe = opnd_a[BYTE_W-1:0];

    for (genvar g = 0; g < RANGE_MAX; g++) begin : g_slot
        logic slot_en;
        assign slot_en = (g == 0) ? 1'b1 : dual_range;
        bcu_range_slot u_slot (
            .en       (slot_en),
            .probe    (probe),
            .lo_bound (opnd_b[g*BOUND_W +: BYTE_W]),
            .hi_bound (opnd_b[g*BOUND_W + BYTE_W +: BYTE_W]),
            .hit      (slot_hit[g])
        );
    end

    assign range_hit = |slot_hit;

    if (MATCH_OK) begin : g_match
        bcu_lane_match #(.LANES(LANES)) u_match (
            .probe   (probe),
            .word    (opnd_b),
            .any_hit (match_hit)
        );
    end else begin : g_no_match
        assign match_hit = 1'b0;
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.cond = gt_field((op_e == OP_MATCH) ? match_hit : range_hit);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign cond_out  = st_q.cond;

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_idle_no_valid_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(cond_out));

    p_only_gt_bit_r10: assert property (@(posedge clk) disable iff (rst)
        (cond_out & 4'b1011) == 4'b0000);

    p_lane0_match_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel && MATCH_OK && opnd_b[7:0] == opnd_a[7:0])
        |=> cond_out == 4'b0100);

    p_bound_hit_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_sel && opnd_a[7:0] == opnd_b[7:0]
         && opnd_b[7:0] <= opnd_b[15:8])
        |=> cond_out == 4'b0100);

endmodule

// File: tb/sim_byte_cmp_unit.sv
module sim_byte_cmp_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        op;
        logic        two;
        logic [63:0] a;
        logic [63:0] b;
        logic        exp;
    } vec_t;

    localparam int NVEC = 20;
    localparam vec_t VEC [NVEC] = '{
        // R4: inside, below, on upper bound, above
        '{1'b0, 1'b0, 64'h41,                  64'h5A41,                1'b1},
        '{1'b0, 1'b0, 64'h40,                  64'h5A41,                1'b0},
        '{1'b0, 1'b0, 64'h5A,                  64'h5A41,                1'b1},
        '{1'b0, 1'b0, 64'h5B,                  64'h5A41,                1'b0},
        // R4: degenerate single-value interval and full span
        '{1'b0, 1'b0, 64'h33,                  64'h3333,                1'b1},
        '{1'b0, 1'b0, 64'h00,                  64'hFF00,                1'b1},
        '{1'b0, 1'b0, 64'hFF,                  64'hFF00,                1'b1},
        // R5: second interval catches the probe
        '{1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FF61, 64'h7A61_5A41,           1'b1},
        // R6: second interval disabled
        '{1'b0, 1'b0, 64'h61,                  64'h7A61_5A41,           1'b0},
        '{1'b0, 1'b1, 64'h61,                  64'h0000_5A41,           1'b0},
        // R7: upper word looks like a matching interval, must be ignored
        '{1'b0, 1'b1, 64'h80,                  64'h8080_8080_0000_0000, 1'b0},
        // R8: inverted intervals
        '{1'b0, 1'b0, 64'h50,                  64'h4060,                1'b0},
        '{1'b0, 1'b1, 64'h50,                  64'h1090_4060,           1'b0},
        // R9: lanes 0 and 7, miss, high bits of a ignored (R3)
        '{1'b1, 1'b0, 64'h77,                  64'h0011_2233_4455_6677, 1'b1},
        '{1'b1, 1'b0, 64'h00,                  64'h0011_2233_4455_6677, 1'b1},
        '{1'b1, 1'b0, 64'h88,                  64'h0011_2233_4455_6677, 1'b0},
        '{1'b1, 1'b0, 64'hAB00_0000_0000_0055, 64'h5501_0101_0101_0101, 1'b1},
        '{1'b1, 1'b0, 64'h1200_0000_0000_00EE, 64'h1212_1212_1212_1212, 1'b0},
        // R9: dual_range has no effect in match mode
        '{1'b1, 1'b1, 64'h99,                  64'h1234_5678_9ABC_DEF0, 1'b0},
        '{1'b1, 1'b1, 64'hBC,                  64'h1234_5678_9ABC_DEF0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        op_sel;
    logic        dual_range;
    logic [63:0] opnd_a;
    logic [63:0] opnd_b;
    logic        out_valid;
    logic [3:0]  cond_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_cmp_unit u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .op_sel     (op_sel),
        .dual_range (dual_range),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .out_valid  (out_valid),
        .cond_out   (cond_out)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got valid/cond %b expected %b", req, act, exp);
        end
    endtask

    task automatic issue(input logic op, input logic two,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid   = 1'b1;
        op_sel     = op;
        dual_range = two;
        opnd_a     = a;
        opnd_b     = b;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    function automatic logic [4:0] want(input logic hit);
        return {1'b1, hit ? 4'b0100 : 4'b0000};
    endfunction

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_sel = 1'b0; dual_range = 1'b0;
        opnd_a = '0; opnd_b = '0;
        repeat (3) @(negedge clk);
        check("R1 reset state", {out_valid, cond_out}, 5'b0_0000);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i].op, VEC[i].two, VEC[i].a, VEC[i].b);
            check($sformatf("R10 vector %0d", i), {out_valid, cond_out}, want(VEC[i].exp));
        end

        // R2/R11: a true result, then idle cycles with changing inputs
        issue(1'b0, 1'b0, 64'h41, 64'h5A41);
        check("R2 valid after request", {out_valid, cond_out}, 5'b1_0100);
        opnd_a = 64'h00; opnd_b = 64'hFFFF;
        @(negedge clk);
        check("R11 hold while idle", {out_valid, cond_out}, 5'b0_0100);
        op_sel = 1'b1; opnd_a = 64'h77;
        @(negedge clk);
        check("R11 hold second idle", {out_valid, cond_out}, 5'b0_0100);

        // R2: back-to-back requests, each result one cycle later
        @(negedge clk);
        in_valid = 1'b1; op_sel = 1'b0; dual_range = 1'b0;
        opnd_a = 64'h20; opnd_b = 64'h1000;
        @(negedge clk);
        check("R2 back-to-back first", {out_valid, cond_out}, 5'b1_0000);
        opnd_a = 64'h05; opnd_b = 64'h0905;
        @(negedge clk);
        check("R2 back-to-back second", {out_valid, cond_out}, 5'b1_0100);
        in_valid = 1'b0;

        // R1: reset in the middle of a request
        issue(1'b1, 1'b0, 64'h11, 64'h11);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears result", {out_valid, cond_out}, 5'b0_0000);
        rst = 1'b0;
        issue(1'b0, 1'b1, 64'hC8, 64'hCCC8_0000);
        check("R5 after reset", {out_valid, cond_out}, 5'b1_0100);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule